// File: doc/BRIEF.md
# Address-Indexed Memory Ordering Checker

This block finds memory-ordering violations without searching a load/store queue. A direct-mapped table is indexed by the low-order bits of each memory address. Each entry keeps two fields: the sequence number of the youngest in-flight store that maps to that slot, and the sequence number of the youngest in-flight load that maps to it. Each field has its own valid bit. When a load or a store issues, it presents its address, its sequence number and its kind. The block compares that sequence number with the opposite field of the addressed entry. One cycle later it raises a violation pulse that carries the sequence number from which the pipeline must restart.

Several addresses can share one entry, so the check is conservative. A violation may be reported that is false, but a real one is never missed. Sequence numbers wrap, and age is always judged by modulo subtraction. The pipeline uses a retire port to drop a field once its operation leaves the window. It uses a flush port to drop every field younger than a squash point. Forwarding of data and the restart itself are handled elsewhere.

Top module: `mdt_top`

## Requirements
- R1: After reset every field is invalid and `viol_vld` is low, so no issue can raise a violation until a field has been written.
- R2: The entry is selected by address bits [IDX_W-1:0] only (bits [6:0] by default). Two addresses that differ only above those bits share an entry and check against each other.
- R3: A store that issues while the entry's load field is valid and holds a sequence number younger than the store raises a violation. The reported sequence number is the recorded load's.
- R4: A load that issues while the entry's store field is valid and holds a sequence number younger than the load raises a violation. The reported sequence number is the issuing load's own.
- R5: No violation is raised when the opposite field is invalid, or when its sequence number is equal to or older than the issuing one.
- R6: Sequence number a is younger than b exactly when (a − b) mod 2^SEQ_W lies in 1 … 2^(SEQ_W−1)−1 (1 … 127 for 8 bits). This holds across wraparound.
- R7: An issue writes the field of its own kind (load or store) only when that field is invalid or holds an older sequence number. Otherwise the stored value is kept.
- R8: A retire clears the field of its kind at its index only when that field is valid and equal to the retiring sequence number. When an issue writes the same field of the same entry in the same cycle, the write wins.
- R9: A flush invalidates every field whose sequence number is strictly younger than the flush point. An issue presented in a flush cycle is ignored: it causes no write and no violation.
- R10: `viol_vld` and `viol_seq` are registered. They appear on the clock edge after the issue edge and last one cycle for each offending issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | 1 | A memory operation issues this cycle |
| iss_is_store | input | 1 | 1 = store, 0 = load |
| iss_addr | input | ADDR_W | Address of the issuing operation |
| iss_seq | input | SEQ_W | Sequence number of the issuing operation |
| ret_vld | input | 1 | A memory operation retires this cycle |
| ret_is_store | input | 1 | 1 = store, 0 = load |
| ret_addr | input | ADDR_W | Address of the retiring operation |
| ret_seq | input | SEQ_W | Sequence number of the retiring operation |
| flush_vld | input | 1 | Squash everything younger than flush_seq |
| flush_seq | input | SEQ_W | Flush point |
| viol_vld | output | 1 | Violation found by the previous cycle's issue |
| viol_seq | output | SEQ_W | Sequence number to restart from |

## Verification
The only results are the violation pulse and its sequence number. Both are due exactly one clock edge after the edge that samples the issue. Table changes made by an issue, a retire or a flush show up only through the outcome of a later issue to the same entry. The bench drives each cycle's inputs after a falling edge. It advances its behavioural model of the table at the rising edge, then compares the outputs with the model's prediction at the next falling edge, so the one-cycle latency is checked on every cycle. Directed sequences reveal stored, overwritten, retired and flushed fields by following them with a probing issue whose expected outcome depends on that field.

// File: rtl/mdt_pkg.sv
package mdt_pkg;

    // Modulo age comparison: a is younger than b when (a - b) mod 2^w
    // is non-zero and lies in the lower half of the number space.
    function automatic logic seq_younger(input logic [31:0] a,
                                         input logic [31:0] b,
                                         input int unsigned w);
        logic [31:0] diff;
        logic [31:0] mask;
        logic [31:0] half;
        diff = a - b;
        mask = (32'd1 << w) - 32'd1;
        half = 32'd1 << (w - 1);
        diff = diff & mask;
        return (diff != 32'd0) && (diff < half);
    endfunction

endpackage

// File: rtl/mdt_table.sv
module mdt_table #(
    parameter int unsigned IDX_W = 7,
    parameter int unsigned SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    // write port (issue)
    input  logic             wr_ld_en,
    input  logic             wr_st_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SEQ_W-1:0] wr_seq,
    // clear port (retire)
    input  logic             clr_ld_en,
    input  logic             clr_st_en,
    input  logic [IDX_W-1:0] clr_idx,
    // flush
    input  logic             flush_vld,
    input  logic [SEQ_W-1:0] flush_seq,
    // read port a (issue side)
    input  logic [IDX_W-1:0] rda_idx,
    output logic             rda_ld_v,
    output logic [SEQ_W-1:0] rda_ld_seq,
    output logic             rda_st_v,
    output logic [SEQ_W-1:0] rda_st_seq,
    // read port b (retire side)
    input  logic [IDX_W-1:0] rdb_idx,
    output logic             rdb_ld_v,
    output logic [SEQ_W-1:0] rdb_ld_seq,
    output logic             rdb_st_v,
    output logic [SEQ_W-1:0] rdb_st_seq
);
    import mdt_pkg::*;

    localparam int unsigned DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic             ld_v;
        logic [SEQ_W-1:0] ld_seq;
        logic             st_v;
        logic [SEQ_W-1:0] st_seq;
    } slot_t;

    slot_t slot_q [DEPTH];
    slot_t slot_d [DEPTH];

    // per-slot flush kill vectors
    logic [DEPTH-1:0] ld_kill;
    logic [DEPTH-1:0] st_kill;

    for (genvar e = 0; e < DEPTH; e++) begin : g_kill
        assign ld_kill[e] = flush_vld && slot_q[e].ld_v &&
                            seq_younger(32'(slot_q[e].ld_seq), 32'(flush_seq), SEQ_W);
        assign st_kill[e] = flush_vld && slot_q[e].st_v &&
                            seq_younger(32'(slot_q[e].st_seq), 32'(flush_seq), SEQ_W);
    end

    always_comb begin
        for (int e = 0; e < DEPTH; e++) begin
            slot_d[e] = slot_q[e];
            // retire clear
            if (clr_ld_en && (clr_idx == IDX_W'(e))) slot_d[e].ld_v = 1'b0;
            if (clr_st_en && (clr_idx == IDX_W'(e))) slot_d[e].st_v = 1'b0;
            // flush invalidation
            if (ld_kill[e]) slot_d[e].ld_v = 1'b0;
            if (st_kill[e]) slot_d[e].st_v = 1'b0;
            // issue write has the last word
            if (wr_ld_en && (wr_idx == IDX_W'(e))) begin
                slot_d[e].ld_v   = 1'b1;
                slot_d[e].ld_seq = wr_seq;
            end
            if (wr_st_en && (wr_idx == IDX_W'(e))) begin
                slot_d[e].st_v   = 1'b1;
                slot_d[e].st_seq = wr_seq;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                slot_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                slot_q[e] <= slot_d[e];
            end
        end
    end

    assign rda_ld_v   = slot_q[rda_idx].ld_v;
    assign rda_ld_seq = slot_q[rda_idx].ld_seq;
    assign rda_st_v   = slot_q[rda_idx].st_v;
    assign rda_st_seq = slot_q[rda_idx].st_seq;
    assign rdb_ld_v   = slot_q[rdb_idx].ld_v;
    assign rdb_ld_seq = slot_q[rdb_idx].ld_seq;
    assign rdb_st_v   = slot_q[rdb_idx].st_v;
    assign rdb_st_seq = slot_q[rdb_idx].st_seq;

endmodule

// File: rtl/mdt_issue_chk.sv
module mdt_issue_chk #(
    parameter int unsigned SEQ_W = 8
) (
    input  logic             iss_vld,
    input  logic             iss_is_store,
    input  logic [SEQ_W-1:0] iss_seq,
    input  logic             flush_vld,
    input  logic             ld_v,
    input  logic [SEQ_W-1:0] ld_seq,
    input  logic             st_v,
    input  logic [SEQ_W-1:0] st_seq,
    output logic             wr_ld_en,
    output logic             wr_st_en,
    output logic             hit,
    output logic [SEQ_W-1:0] hit_seq
);
    import mdt_pkg::*;

    logic act;
    logic ld_newer;   // recorded load younger than issuing op
    logic st_newer;   // recorded store younger than issuing op
    logic iss_over_ld;
    logic iss_over_st;

    always_comb begin
        act         = iss_vld && !flush_vld;
        ld_newer    = ld_v && seq_younger(32'(ld_seq), 32'(iss_seq), SEQ_W);
        st_newer    = st_v && seq_younger(32'(st_seq), 32'(iss_seq), SEQ_W);
        iss_over_ld = !ld_v || seq_younger(32'(iss_seq), 32'(ld_seq), SEQ_W);
        iss_over_st = !st_v || seq_younger(32'(iss_seq), 32'(st_seq), SEQ_W);

        wr_ld_en = act && !iss_is_store && iss_over_ld;
        wr_st_en = act &&  iss_is_store && iss_over_st;

        hit     = 1'b0;
        hit_seq = iss_seq;
        if (act) begin
            if (iss_is_store) begin
                hit     = ld_newer;
                hit_seq = ld_seq;
            end else begin
                hit     = st_newer;
                hit_seq = iss_seq;
            end
        end
    end

endmodule

// File: rtl/mdt_retire_chk.sv
module mdt_retire_chk #(
    parameter int unsigned SEQ_W = 8
) (
    input  logic             ret_vld,
    input  logic             ret_is_store,
    input  logic [SEQ_W-1:0] ret_seq,
    input  logic             ld_v,
    input  logic [SEQ_W-1:0] ld_seq,
    input  logic             st_v,
    input  logic [SEQ_W-1:0] st_seq,
    output logic             clr_ld_en,
    output logic             clr_st_en
);
    always_comb begin
        clr_ld_en = ret_vld && !ret_is_store && ld_v && (ld_seq == ret_seq);
        clr_st_en = ret_vld &&  ret_is_store && st_v && (st_seq == ret_seq);
    end
endmodule

// File: rtl/mdt_top.sv
module mdt_top #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 7,
    parameter int unsigned SEQ_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_vld,
    input  logic              iss_is_store,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic [SEQ_W-1:0]  iss_seq,
    input  logic              ret_vld,
    input  logic              ret_is_store,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [SEQ_W-1:0]  ret_seq,
    input  logic              flush_vld,
    input  logic [SEQ_W-1:0]  flush_seq,
    output logic              viol_vld,
    output logic [SEQ_W-1:0]  viol_seq
);
    typedef struct packed {
        logic             vld;
        logic [SEQ_W-1:0] seq;
    } viol_t;

    viol_t viol_d, viol_q;

    logic [IDX_W-1:0] iss_idx;
    logic [IDX_W-1:0] ret_idx;
    logic             unused_addr_hi;

    assign iss_idx        = iss_addr[IDX_W-1:0];
    assign ret_idx        = ret_addr[IDX_W-1:0];
    assign unused_addr_hi = ^{iss_addr[ADDR_W-1:IDX_W], ret_addr[ADDR_W-1:IDX_W]};

    logic             a_ld_v, a_st_v, b_ld_v, b_st_v;
    logic [SEQ_W-1:0] a_ld_seq, a_st_seq, b_ld_seq, b_st_seq;
    logic             wr_ld_en, wr_st_en, clr_ld_en, clr_st_en;
    logic             hit;
    logic [SEQ_W-1:0] hit_seq;

    mdt_issue_chk #(.SEQ_W(SEQ_W)) i_issue (
        .iss_vld      (iss_vld),
        .iss_is_store (iss_is_store),
        .iss_seq      (iss_seq),
        .flush_vld    (flush_vld),
        .ld_v         (a_ld_v),
        .ld_seq       (a_ld_seq),
        .st_v         (a_st_v),
        .st_seq       (a_st_seq),
        .wr_ld_en     (wr_ld_en),
        .wr_st_en     (wr_st_en),
        .hit          (hit),
        .hit_seq      (hit_seq)
    );

    mdt_retire_chk #(.SEQ_W(SEQ_W)) i_retire (
        .ret_vld      (ret_vld),
        .ret_is_store (ret_is_store),
        .ret_seq      (ret_seq),
        .ld_v         (b_ld_v),
        .ld_seq       (b_ld_seq),
        .st_v         (b_st_v),
        .st_seq       (b_st_seq),
        .clr_ld_en    (clr_ld_en),
        .clr_st_en    (clr_st_en)
    );

    mdt_table #(.IDX_W(IDX_W), .SEQ_W(SEQ_W)) i_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ld_en   (wr_ld_en),
        .wr_st_en   (wr_st_en),
        .wr_idx     (iss_idx),
        .wr_seq     (iss_seq),
        .clr_ld_en  (clr_ld_en),
        .clr_st_en  (clr_st_en),
        .clr_idx    (ret_idx),
        .flush_vld  (flush_vld),
        .flush_seq  (flush_seq),
        .rda_idx    (iss_idx),
        .rda_ld_v   (a_ld_v),
        .rda_ld_seq (a_ld_seq),
        .rda_st_v   (a_st_v),
        .rda_st_seq (a_st_seq),
        .rdb_idx    (ret_idx),
        .rdb_ld_v   (b_ld_v),
        .rdb_ld_seq (b_ld_seq),
        .rdb_st_v   (b_st_v),
        .rdb_st_seq (b_st_seq)
    );

    always_comb begin
        viol_d     = viol_q;
        viol_d.vld = hit;
        if (hit) viol_d.seq = hit_seq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) viol_q <= '0;
        else        viol_q <= viol_d;
    end

    assign viol_vld = viol_q.vld;
    assign viol_seq = viol_q.seq;

endmodule

// File: rtl/mdt_chk.sv
module mdt_chk #(
    parameter int unsigned SEQ_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_vld,
    input logic             iss_is_store,
    input logic [SEQ_W-1:0] iss_seq,
    input logic             flush_vld,
    input logic             viol_vld,
    input logic [SEQ_W-1:0] viol_seq
);
    import mdt_pkg::*;

    // R9
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_vld |=> !viol_vld);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_vld |=> !viol_vld);

    // R4
    load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && !iss_is_store && !flush_vld) |=>
            (!viol_vld || (viol_seq == $past(iss_seq))));

    // R3
    store_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && iss_is_store && !flush_vld) |=>
            (!viol_vld || seq_younger(32'(viol_seq), 32'($past(iss_seq)), SEQ_W)));

endmodule

bind mdt_top mdt_chk #(.SEQ_W(SEQ_W)) i_mdt_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .iss_vld      (iss_vld),
    .iss_is_store (iss_is_store),
    .iss_seq      (iss_seq),
    .flush_vld    (flush_vld),
    .viol_vld     (viol_vld),
    .viol_seq     (viol_seq)
);

// File: tb/test_mdt_top.sv
module test_mdt_top;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 7;
    localparam int SEQ_W  = 8;
    localparam int DEPTH  = 128;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              iss_vld = 1'b0, iss_is_store = 1'b0;
    logic [ADDR_W-1:0] iss_addr = '0, ret_addr = '0;
    logic [SEQ_W-1:0]  iss_seq = '0, ret_seq = '0, flush_seq = '0;
    logic              ret_vld = 1'b0, ret_is_store = 1'b0, flush_vld = 1'b0;
    logic              viol_vld;
    logic [SEQ_W-1:0]  viol_seq;

    always #2 clk = ~clk;

    mdt_top #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEQ_W(SEQ_W)) i_mdt_top (
        .clk(clk), .rst_n(rst_n),
        .iss_vld(iss_vld), .iss_is_store(iss_is_store), .iss_addr(iss_addr), .iss_seq(iss_seq),
        .ret_vld(ret_vld), .ret_is_store(ret_is_store), .ret_addr(ret_addr), .ret_seq(ret_seq),
        .flush_vld(flush_vld), .flush_seq(flush_seq),
        .viol_vld(viol_vld), .viol_seq(viol_seq));

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // behavioural model of the table
    bit m_lv [DEPTH];
    int m_ls [DEPTH];
    bit m_sv [DEPTH];
    int m_ss [DEPTH];
    bit exp_v;
    int exp_s;

    function automatic bit young(int a, int b);
        int d;
        d = (a - b) & 255;
        return (d >= 1) && (d <= 127);
    endfunction

    task automatic model_edge();
        int ii, ri;
        bit pl_v, ps_v, wl, ws;
        int pl_s, ps_s;
        ii = int'(iss_addr) & (DEPTH - 1);
        ri = int'(ret_addr) & (DEPTH - 1);
        pl_v = m_lv[ii]; pl_s = m_ls[ii]; ps_v = m_sv[ii]; ps_s = m_ss[ii];
        exp_v = 0; wl = 0; ws = 0;
        if (iss_vld && !flush_vld) begin
            if (iss_is_store) begin
                if (pl_v && young(pl_s, int'(iss_seq))) begin exp_v = 1; exp_s = pl_s; end
                ws = !ps_v || young(int'(iss_seq), ps_s);
            end else begin
                if (ps_v && young(ps_s, int'(iss_seq))) begin exp_v = 1; exp_s = int'(iss_seq); end
                wl = !pl_v || young(int'(iss_seq), pl_s);
            end
        end
        if (ret_vld) begin
            if (!ret_is_store && m_lv[ri] && m_ls[ri] == int'(ret_seq)) m_lv[ri] = 0;
            if ( ret_is_store && m_sv[ri] && m_ss[ri] == int'(ret_seq)) m_sv[ri] = 0;
        end
        if (flush_vld) begin
            for (int e = 0; e < DEPTH; e++) begin
                if (m_lv[e] && young(m_ls[e], int'(flush_seq))) m_lv[e] = 0;
                if (m_sv[e] && young(m_ss[e], int'(flush_seq))) m_sv[e] = 0;
            end
        end
        if (wl) begin m_lv[ii] = 1; m_ls[ii] = int'(iss_seq); end
        if (ws) begin m_sv[ii] = 1; m_ss[ii] = int'(iss_seq); end
    endtask

    task automatic compare(string tag);
        n_tests++;
        if (viol_vld !== exp_v || (exp_v && int'(viol_seq) != exp_s)) begin
            n_fail++;
            $display("FAIL %s: viol_vld=%0b viol_seq=%0d expected viol_vld=%0b viol_seq=%0d",
                     tag, viol_vld, viol_seq, exp_v, exp_s);
        end
    endtask

    task automatic step(bit iv, bit ist, int ia, int is,
                        bit rv, bit rs, int ra, int rsq,
                        bit fv, int fs, string tag);
        iss_vld = iv; iss_is_store = ist; iss_addr = ADDR_W'(ia); iss_seq = SEQ_W'(is);
        ret_vld = rv; ret_is_store = rs; ret_addr = ADDR_W'(ra); ret_seq = SEQ_W'(rsq);
        flush_vld = fv; flush_seq = SEQ_W'(fs);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic ld(int a, int s, string t); step(1,0,a,s, 0,0,0,0, 0,0, t); endtask
    task automatic st(int a, int s, string t); step(1,1,a,s, 0,0,0,0, 0,0, t); endtask
    task automatic idle(string t);             step(0,0,0,0, 0,0,0,0, 0,0, t); endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        for (int e = 0; e < DEPTH; e++) begin m_lv[e] = 0; m_sv[e] = 0; m_ls[e] = 0; m_ss[e] = 0; end
        exp_v = 0; exp_s = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: empty after reset, old store probes find nothing
        compare("R1 reset");
        st(8'h10, 5, "R1 store after reset");
        idle("R1 no pulse");
        // R3: store older than recorded load
        ld(8'h20, 20, "R3 load");
        st(8'h20, 15, "R3 store older than load");
        idle("R10 single pulse");
        // R5: store younger than load, equal seq
        st(8'h20, 25, "R5 younger store");
        st(8'h20, 20, "R5 equal seq");
        // R2: aliasing
        ld(32'h0000_0035, 40, "R2 load");
        st(32'h1234_00B5, 38, "R2 alias store");
        st(32'h0000_0036, 30, "R2 other index");
        // R4: load older than recorded store
        st(8'h50, 60, "R4 store");
        ld(8'h50, 55, "R4 older load");
        ld(8'h50, 61, "R5 younger load");
        // R6: wraparound
        ld(8'h60, 3, "R6 load");
        st(8'h60, 250, "R6 wrapped older store");
        st(8'h60, 130, "R6 half-range store");
        // R7: no overwrite by older issue
        ld(8'h70, 80, "R7 load");
        ld(8'h70, 70, "R7 older load");
        st(8'h70, 75, "R7 probe");
        // R8: retire exact match only
        ld(8'h11, 90, "R8 load");
        step(0,0,0,0, 1,0,8'h11,89, 0,0, "R8 mismatched retire");
        st(8'h11, 85, "R8 probe after mismatch");
        step(0,0,0,0, 1,0,8'h11,90, 0,0, "R8 matching retire");
        st(8'h11, 86, "R8 probe after retire");
        ld(8'h14, 140, "R8 load");
        step(1,0,8'h14,150, 1,0,8'h14,140, 0,0, "R8 write beats retire");
        st(8'h14, 145, "R8 probe written field");
        // R9: flush
        ld(8'h12, 100, "R9 load a");
        ld(8'h13, 110, "R9 load b");
        step(1,1,8'h12,95, 0,0,0,0, 1,105, "R9 issue during flush");
        st(8'h13, 100, "R9 flushed field");
        st(8'h12, 99, "R9 kept field");
        // random mix
        begin
            int base = 200;
            for (int c = 0; c < 2000; c++) begin
                int r = $urandom_range(0, 99);
                int a = int'($urandom_range(0, 3)) | (int'($urandom_range(0, 7)) << 7);
                int s = (base + int'($urandom_range(0, 20))) & 255;
                bit rv = ($urandom_range(0, 3) == 0);
                int ra = int'($urandom_range(0, 3));
                int rsq = (base + int'($urandom_range(0, 20))) & 255;
                bit fv = (r < 3);
                if ($urandom_range(0, 2) == 0) base = (base + 1) & 255;
                step(r < 80, $urandom_range(0, 1) == 1, a, s,
                     rv, $urandom_range(0, 1) == 1, ra, rsq,
                     fv, (base + 10) & 255, "R3 R4 R8 R9 random");
            end
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule